// File: doc/BRIEF.md
# Lock-Aware Round-Robin Victim Way Selector

This block holds one replacement pointer for every set of a 32-way set-associative cache and names the way that the next line fill of a set must overwrite. A fill strobe with a set index advances the pointer of that set alone, to the way after the one just written. Every pointer comes out of reset on the highest way, so the first fill of a set lands there.

When the pointer of a set moves on from the highest way, it does not return to way 0 blindly. Each set reports how many of its low-numbered ways are locked, and the wrap lands on the first unlocked way. A set whose ways are all locked has no victim: the block raises a no-allocate flag for it and its pointer does not move on a fill.

The victim is read combinationally for a queried set, from the stored pointer, so a fill and a query to the same set in one cycle see the value from before the fill.

Top module: `rr_victim_sel`

## Requirements
- R1: After reset, every set reports victim way NUM_WAYS-1 (31 by default).
- R2: A fill into a set whose pointer is below NUM_WAYS-1 and whose lock count is below NUM_WAYS moves that pointer to the current value plus one in the next cycle.
- R3: A fill into one set leaves the pointer of every other set unchanged.
- R4: A fill into a set whose pointer is NUM_WAYS-1 and whose lock count is 0 moves the pointer to way 0.
- R5: A fill into a set whose pointer is NUM_WAYS-1 and whose lock count is N, with 0 < N < NUM_WAYS, moves the pointer to way N (three locked ways give way 3).
- R6: victim_way_o equals the stored pointer of the set on query_set_i in the same cycle; with a fill to that set in the same cycle it shows the value from before the fill.
- R7: no_alloc_o is 1 exactly when the lock count of the queried set equals NUM_WAYS; a fill into such a set leaves its pointer unchanged.
- R8: With fill_i low no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_i | input | 1 | Line fill strobe |
| fill_set_i | input | SET_W | Set receiving the fill |
| lock_cnt_i | input | NUM_SETS*LOCK_W | Per-set count of locked low ways, set s at bits [s*LOCK_W +: LOCK_W] |
| query_set_i | input | SET_W | Set whose victim is read |
| victim_way_o | output | WAY_W | Victim way of the queried set |
| no_alloc_o | output | 1 | Queried set has every way locked |

## Verification
The assertions watch one queried set at a time and draw conclusions only when the queried set stays the same across two cycles, so they assume the lock count of that set is stable over the fill it judges. The stimulus changes lock counts only in cycles without a fill to that set in the directed part, and the random part compares every cycle against a behavioural model instead of relying on the properties. Lock counts are kept in the range 0 to NUM_WAYS, the only values the block defines.

// File: rtl/rr_victim_pkg.sv
package rr_victim_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_WRAP = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/rr_next_ptr.sv
module rr_next_ptr
  import rr_victim_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 32,
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
  localparam int unsigned LOCK_W = $clog2(NUM_WAYS + 1)
) (
  input  logic              fill_hit_i,
  input  logic [WAY_W-1:0]  cur_i,
  input  logic [LOCK_W-1:0] lock_cnt_i,
  output logic [WAY_W-1:0]  nxt_o
);
  localparam logic [WAY_W-1:0]  LAST_WAY = WAY_W'(NUM_WAYS - 1);
  localparam logic [LOCK_W-1:0] ALL_LOCK = LOCK_W'(NUM_WAYS);

  ptr_op_e op;

  always_comb begin
    op = PTR_HOLD;
    if (fill_hit_i && lock_cnt_i < ALL_LOCK) begin
      op = (cur_i == LAST_WAY) ? PTR_WRAP : PTR_STEP;
    end
  end

  always_comb begin
    unique case (op)
      PTR_STEP: nxt_o = cur_i + WAY_W'(1);
      PTR_WRAP: nxt_o = WAY_W'(lock_cnt_i); // first unlocked way
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/rr_ptr_bank.sv
module rr_ptr_bank #(
  parameter int unsigned NUM_WAYS = 32,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LOCK_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fill_i,
  input  logic [SET_W-1:0]           fill_set_i,
  input  logic [NUM_SETS*LOCK_W-1:0] lock_cnt_i,
  output logic [NUM_SETS*WAY_W-1:0]  ptr_o
);
  localparam logic [WAY_W-1:0] RST_WAY = WAY_W'(NUM_WAYS - 1);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic             hit;
    logic [WAY_W-1:0] ptr_q;
    logic [WAY_W-1:0] ptr_d;

    assign hit = fill_i && (fill_set_i == SET_W'(s));

    rr_next_ptr #(.NUM_WAYS(NUM_WAYS)) next_i (
      .fill_hit_i (hit),
      .cur_i      (ptr_q),
      .lock_cnt_i (lock_cnt_i[s*LOCK_W +: LOCK_W]),
      .nxt_o      (ptr_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q <= RST_WAY;
      else         ptr_q <= ptr_d;
    end

    assign ptr_o[s*WAY_W +: WAY_W] = ptr_q;
  end
endmodule

// File: rtl/rr_query_mux.sv
module rr_query_mux #(
  parameter int unsigned NUM_WAYS = 32,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LOCK_W = $clog2(NUM_WAYS + 1)
) (
  input  logic [SET_W-1:0]           query_set_i,
  input  logic [NUM_SETS*WAY_W-1:0]  ptr_i,
  input  logic [NUM_SETS*LOCK_W-1:0] lock_cnt_i,
  output logic [WAY_W-1:0]           victim_way_o,
  output logic                       no_alloc_o
);
  logic [LOCK_W-1:0] q_lock;

  always_comb begin
    victim_way_o = '0;
    q_lock       = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (query_set_i == SET_W'(s)) begin
        victim_way_o = ptr_i[s*WAY_W +: WAY_W];
        q_lock       = lock_cnt_i[s*LOCK_W +: LOCK_W];
      end
    end
  end

  assign no_alloc_o = (q_lock == LOCK_W'(NUM_WAYS));
endmodule

// File: rtl/rr_victim_sel.sv
module rr_victim_sel #(
  parameter int unsigned NUM_WAYS = 32,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LOCK_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fill_i,
  input  logic [SET_W-1:0]           fill_set_i,
  input  logic [NUM_SETS*LOCK_W-1:0] lock_cnt_i,
  input  logic [SET_W-1:0]           query_set_i,
  output logic [WAY_W-1:0]           victim_way_o,
  output logic                       no_alloc_o
);
  logic [NUM_SETS*WAY_W-1:0] ptr_all;

  rr_ptr_bank #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (fill_i),
    .fill_set_i (fill_set_i),
    .lock_cnt_i (lock_cnt_i),
    .ptr_o      (ptr_all)
  );

  rr_query_mux #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) mux_i (
    .query_set_i  (query_set_i),
    .ptr_i        (ptr_all),
    .lock_cnt_i   (lock_cnt_i),
    .victim_way_o (victim_way_o),
    .no_alloc_o   (no_alloc_o)
  );
endmodule

// File: rtl/rr_victim_sel_chk.sv
module rr_victim_sel_chk #(
  parameter int unsigned NUM_WAYS = 32,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS),
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LOCK_W = $clog2(NUM_WAYS + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       fill_i,
  input logic [SET_W-1:0]           fill_set_i,
  input logic [NUM_SETS*LOCK_W-1:0] lock_cnt_i,
  input logic [SET_W-1:0]           query_set_i,
  input logic [WAY_W-1:0]           victim_way_o,
  input logic                       no_alloc_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic [LOCK_W-1:0] q_lock;
  logic              same_fill;
  assign q_lock    = lock_cnt_i[query_set_i*LOCK_W +: LOCK_W];
  assign same_fill = fill_i && (fill_set_i == query_set_i);

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_fill && !no_alloc_o && victim_way_o != LAST_WAY)
    |=> (query_set_i != $past(query_set_i)) ||
        (victim_way_o == WAY_W'($past(victim_way_o) + WAY_W'(1))));

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_fill && !no_alloc_o && victim_way_o == LAST_WAY)
    |=> (query_set_i != $past(query_set_i)) ||
        ({1'b0, victim_way_o} == LOCK_W'($past(q_lock))));

  // R3
  other_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fill_set_i != query_set_i)
    |=> (query_set_i != $past(query_set_i)) || $stable(victim_way_o));

  // R7
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_fill && no_alloc_o)
    |=> (query_set_i != $past(query_set_i)) || $stable(victim_way_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> (query_set_i != $past(query_set_i)) || $stable(victim_way_o));
endmodule

bind rr_victim_sel rr_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_i       (fill_i),
  .fill_set_i   (fill_set_i),
  .lock_cnt_i   (lock_cnt_i),
  .query_set_i  (query_set_i),
  .victim_way_o (victim_way_o),
  .no_alloc_o   (no_alloc_o)
);

// File: tb/rr_victim_sel_tb.sv
module rr_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 32;
  localparam int NS = 16;
  localparam int WW = $clog2(NW);
  localparam int SW = $clog2(NS);
  localparam int LW = $clog2(NW + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fill_i = 1'b0;
  logic [SW-1:0]     fill_set_i = '0;
  logic [NS*LW-1:0]  lock_cnt_i = '0;
  logic [SW-1:0]     query_set_i = '0;
  logic [WW-1:0]     victim_way_o;
  logic              no_alloc_o;

  int ref_ptr [NS];
  int lock_m  [NS];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rr_victim_sel #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut_i (
    .clk_i, .rst_ni, .fill_i, .fill_set_i, .lock_cnt_i,
    .query_set_i, .victim_way_o, .no_alloc_o
  );

  task automatic check(input string tag, input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  // drive at negedge, compare pre-edge outputs, then advance model on posedge
  task automatic step(input bit f, input int fs, input int qs, input string tag);
    fill_i      = f;
    fill_set_i  = SW'(fs);
    query_set_i = SW'(qs);
    for (int s = 0; s < NS; s++) lock_cnt_i[s*LW +: LW] = LW'(lock_m[s]);
    #1;
    check(tag, int'(victim_way_o), ref_ptr[qs], "victim");
    check(tag, int'(no_alloc_o), (lock_m[qs] == NW) ? 1 : 0, "no_alloc");
    @(posedge clk_i);
    if (f && lock_m[fs] < NW) begin
      if (ref_ptr[fs] == NW - 1) ref_ptr[fs] = lock_m[fs];
      else                       ref_ptr[fs] = ref_ptr[fs] + 1;
    end
    @(negedge clk_i);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      ref_ptr[s] = NW - 1;
      lock_m[s]  = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int s = 0; s < NS; s++) step(1'b0, 0, s, "R1");
    // R4 wrap with no locks, R6 same-cycle read shows old value
    step(1'b1, 0, 0, "R6");
    step(1'b0, 0, 0, "R4");
    // R2 plain increments
    for (int i = 0; i < 4; i++) step(1'b1, 0, 0, "R2");
    // R3 fills elsewhere leave set 0 alone
    for (int i = 0; i < 3; i++) step(1'b1, 5, 0, "R3");
    // R5 wrap lands past three locked ways
    lock_m[1] = 3;
    step(1'b0, 1, 1, "R5");
    step(1'b1, 1, 1, "R5");
    step(1'b0, 1, 1, "R5");
    // R5 with 31 locked: wrap returns to the last way
    lock_m[4] = NW - 1;
    step(1'b0, 4, 4, "R5");
    step(1'b1, 4, 4, "R5");
    step(1'b1, 4, 4, "R5");
    // R7 fully locked set
    lock_m[2] = NW;
    step(1'b0, 2, 2, "R7");
    step(1'b1, 2, 2, "R7");
    step(1'b0, 2, 2, "R7");
    lock_m[2] = 0;
    step(1'b0, 2, 2, "R7");
    // R8 idle cycles
    for (int i = 0; i < 5; i++) step(1'b0, i, 0, "R8");
    // mixed traffic, R6 against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      int fs;
      int qs;
      fs = int'($urandom_range(NS - 1, 0));
      qs = ($urandom_range(3, 0) == 0) ? fs : int'($urandom_range(NS - 1, 0));
      if ($urandom_range(15, 0) == 0) begin
        int sel;
        sel = int'($urandom_range(NS - 1, 0));
        case ($urandom_range(3, 0))
          0: lock_m[sel] = 0;
          1: lock_m[sel] = NW;
          default: lock_m[sel] = int'($urandom_range(NW - 1, 0));
        endcase
      end
      step($urandom_range(1, 0) == 1, fs, qs, "R6");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule